// File: doc/BRIEF.md
# Kernel Call Sequence Event Detector

This block sits beside a processor that runs a preemptive real-time kernel. It watches the processor's address bus and never drives it. Software loads the entry addresses of five kernel routines through a small configuration port: reschedule, semaphore lock, semaphore unlock, interrupt entry and I/O request. On every clock cycle the block compares the bus address with each loaded entry.

The block never sees the arguments of a kernel call, so it works out the cause of each reschedule from the order of the calls alone. It keeps the last recognised non-reschedule call as a pending prefix. A reschedule call closes the prefix and produces a one-cycle event strobe with a 3-bit cause code. If the prefix was a semaphore lock, the lock found the semaphore already taken, and the block also raises a flag that tells downstream list-maintenance logic to remove the running task from the ready list. An interrupt entry followed by a reschedule is reported as a tick, so no separate tick wire is needed.

Top module: `kcall_event_detector`

## Requirements
- R1: After reset `evt_valid`, `evt_code` and `evt_leave_ready` are 0 and no prefix is pending.
- R2: A configuration write with `cfg_sel` set to 0 (reschedule), 1 (lock), 2 (unlock), 3 (interrupt) or 4 (I/O) loads `cfg_addr` into that entry and arms it. The write takes effect from the next cycle. Entries that have never been written never match. Writes with `cfg_sel` set to 5, 6 or 7 have no effect.
- R3: An entry matches in a cycle only when `bus_valid` is 1 and `bus_addr` equals the entry's address.
- R4: An interrupt call followed by a reschedule call gives `evt_code` 3'd1 (tick). The strobe appears in the cycle after the reschedule address is sampled.
- R5: An I/O call followed by a reschedule call gives `evt_code` 3'd2.
- R6: A lock call followed by a reschedule call gives `evt_code` 3'd3 with `evt_leave_ready` 1. For every other code, `evt_leave_ready` is 0.
- R7: An unlock call followed by a reschedule call gives `evt_code` 3'd4 (wake).
- R8: A reschedule call with no pending prefix gives `evt_code` 3'd7 (unclassified).
- R9: A recognised non-reschedule call replaces any pending prefix.
- R10: A matching address held in consecutive cycles counts as one call. A cycle with no match, or a match on a different entry, ends the call.
- R11: Each event is a one-cycle strobe, and the reschedule that produces it clears the pending prefix.
- R12: When more than one armed entry matches, the lowest `cfg_sel` index wins, so the reschedule entry takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Index of the entry to load |
| cfg_addr | input | ADDR_W | Routine entry address to load |
| bus_valid | input | 1 | Bus address is valid this cycle |
| bus_addr | input | ADDR_W | Observed processor address |
| evt_valid | output | 1 | One-cycle scheduling event strobe |
| evt_code | output | 3 | Event cause: 1 tick, 2 I/O, 3 block, 4 wake, 7 unclassified |
| evt_leave_ready | output | 1 | Running task should leave the ready list |

## Verification
The bench builds the block with a 12-bit address width. This keeps the routine addresses short and readable, and lets two entries share one address to exercise the match priority. Every decode path, the replacement of a pending prefix, held and back-to-back calls, ignored selector values and unarmed entries are all reachable within a few hundred cycles, and a behavioural model checks the outputs on every clock.

// File: rtl/kcall_pkg.sv
package kcall_pkg;
    localparam int NUM_ROUTINES = 5;
    localparam int SEL_W        = 3;

    typedef enum logic [SEL_W-1:0] {
        RT_RESCHED = 3'd0,
        RT_LOCK    = 3'd1,
        RT_UNLOCK  = 3'd2,
        RT_INT     = 3'd3,
        RT_IO      = 3'd4
    } routine_e;

    typedef enum logic [2:0] {
        PEND_IDLE,
        PEND_LOCK,
        PEND_UNLOCK,
        PEND_INT,
        PEND_IO
    } pend_e;

    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_TICK    = 3'd1,
        EV_IO      = 3'd2,
        EV_BLOCK   = 3'd3,
        EV_WAKE    = 3'd4,
        EV_UNCLASS = 3'd7
    } event_e;
endpackage

// File: rtl/kcall_addr_table.sv
module kcall_addr_table
    import kcall_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N      = NUM_ROUTINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [N-1:0]      match
);
    typedef struct packed {
        logic [N-1:0]             armed;
        logic [N-1:0][ADDR_W-1:0] addr;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < N; i++) begin
            if (cfg_we && (cfg_sel == SEL_W'(i))) begin
                tbl_d.armed[i] = 1'b1;
                tbl_d.addr[i]  = cfg_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = tbl_q.armed[g] && bus_valid && (bus_addr == tbl_q.addr[g]);
    end

    // R3
    no_match_without_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (match == '0));
endmodule

// File: rtl/kcall_call_filter.sv
module kcall_call_filter
    import kcall_pkg::*;
#(
    parameter int N = NUM_ROUTINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     match,
    output logic             call_new,
    output logic [SEL_W-1:0] call_id
);
    typedef struct packed {
        logic             hit;
        logic [SEL_W-1:0] id;
    } flt_t;

    flt_t flt_d, flt_q;
    logic hit;

    always_comb begin
        hit     = |match;
        call_id = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) call_id = SEL_W'(i);
        end
        call_new  = hit && !(flt_q.hit && (flt_q.id == call_id));
        flt_d.hit = hit;
        flt_d.id  = call_id;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    // R10
    dedup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_new |=> !(call_new && (call_id == $past(call_id))));
endmodule

// File: rtl/kcall_seq_fsm.sv
module kcall_seq_fsm
    import kcall_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_new,
    input  logic [SEL_W-1:0] call_id,
    output logic             evt_valid,
    output logic [2:0]       evt_code,
    output logic             evt_leave
);
    typedef struct packed {
        pend_e  pend;
        logic   v;
        event_e code;
        logic   leave;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        seq_d.v     = 1'b0;
        seq_d.code  = EV_NONE;
        seq_d.leave = 1'b0;
        if (call_new) begin
            if (call_id == RT_RESCHED) begin
                seq_d.v    = 1'b1;
                seq_d.pend = PEND_IDLE;
                unique case (seq_q.pend)
                    PEND_LOCK:   begin seq_d.code = EV_BLOCK; seq_d.leave = 1'b1; end
                    PEND_UNLOCK: seq_d.code = EV_WAKE;
                    PEND_INT:    seq_d.code = EV_TICK;
                    PEND_IO:     seq_d.code = EV_IO;
                    default:     seq_d.code = EV_UNCLASS;
                endcase
            end else begin
                unique case (call_id)
                    RT_LOCK:   seq_d.pend = PEND_LOCK;
                    RT_UNLOCK: seq_d.pend = PEND_UNLOCK;
                    RT_INT:    seq_d.pend = PEND_INT;
                    RT_IO:     seq_d.pend = PEND_IO;
                    default:   seq_d.pend = seq_q.pend;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{pend: PEND_IDLE, v: 1'b0, code: EV_NONE, leave: 1'b0};
        else        seq_q <= seq_d;
    end

    assign evt_valid = seq_q.v;
    assign evt_code  = seq_q.code;
    assign evt_leave = seq_q.leave;

    // R11
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid);

    // R6
    block_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_new && (call_id == RT_RESCHED) && (seq_q.pend == PEND_LOCK))
        |=> (evt_valid && evt_leave && (evt_code == EV_BLOCK)));

    // R8
    event_needs_resched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> ($past(call_new) && ($past(call_id) == RT_RESCHED)));

    // R9
    prefix_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_new && (call_id != RT_RESCHED)) |=> (seq_q.pend != PEND_IDLE));
endmodule

// File: rtl/kcall_event_detector.sv
module kcall_event_detector
    import kcall_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              evt_valid,
    output logic [2:0]        evt_code,
    output logic              evt_leave_ready
);
    logic [NUM_ROUTINES-1:0] match;
    logic                    call_new;
    logic [SEL_W-1:0]        call_id;

    kcall_addr_table #(.ADDR_W(ADDR_W), .N(NUM_ROUTINES)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_addr  (cfg_addr),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .match     (match)
    );

    kcall_call_filter #(.N(NUM_ROUTINES)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .call_new (call_new),
        .call_id  (call_id)
    );

    kcall_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .call_new  (call_new),
        .call_id   (call_id),
        .evt_valid (evt_valid),
        .evt_code  (evt_code),
        .evt_leave (evt_leave_ready)
    );

    // R12
    resched_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match[0] |-> (call_id == RT_RESCHED));
endmodule

// File: tb/test_kcall_event_detector.sv
module test_kcall_event_detector;
    localparam int AW = 12;
    localparam logic [AW-1:0] A_RS = 12'h3A0, A_LK = 12'h104, A_UL = 12'h108,
                              A_IN = 12'h010, A_IO = 12'h220, A_X = 12'h555;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_addr = '0;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          evt_valid;
    logic [2:0]    evt_code;
    logic          evt_leave_ready;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    kcall_event_detector #(.ADDR_W(AW)) i_kcall_event_detector (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_leave_ready(evt_leave_ready)
    );

    // Behavioural reference model
    bit          m_armed [5];
    int          m_addr  [5];
    bit          m_prev_hit;
    int          m_prev_id, m_pend;
    bit          m_v, m_leave;
    int          m_code;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_armed[i]) begin m_armed[i] = 0; m_addr[i] = 0; end
            m_prev_hit = 0; m_prev_id = 0; m_pend = 0;
            m_v = 0; m_code = 0; m_leave = 0;
        end else begin
            bit hit; int id; bit newc;
            hit = 0; id = 0;
            for (int i = 4; i >= 0; i--)
                if (m_armed[i] && bus_valid && (int'(bus_addr) == m_addr[i])) begin hit = 1; id = i; end
            newc = hit && !(m_prev_hit && m_prev_id == id);
            m_v = 0; m_code = 0; m_leave = 0;
            if (newc) begin
                if (id == 0) begin
                    m_v = 1;
                    if      (m_pend == 1) begin m_code = 3; m_leave = 1; end
                    else if (m_pend == 2) m_code = 4;
                    else if (m_pend == 3) m_code = 1;
                    else if (m_pend == 4) m_code = 2;
                    else                  m_code = 7;
                    m_pend = 0;
                end else m_pend = id;
            end
            m_prev_hit = hit; m_prev_id = id;
            if (cfg_we && cfg_sel < 5) begin
                m_armed[cfg_sel] = 1; m_addr[cfg_sel] = int'(cfg_addr);
            end
        end
    end

    // Per-cycle comparison and event monitor
    int ev_cnt = 0;
    int ev_code = 0;
    bit ev_leave = 0;

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (evt_valid !== m_v || int'(evt_code) !== m_code || evt_leave_ready !== m_leave) begin
                errors++;
                $display("FAIL model R11 per-cycle: actual v=%0b code=%0d leave=%0b expected v=%0b code=%0d leave=%0b",
                         evt_valid, evt_code, evt_leave_ready, m_v, m_code, m_leave);
            end
            if (evt_valid) begin
                ev_cnt++; ev_code = int'(evt_code); ev_leave = evt_leave_ready;
            end
        end
    end

    task automatic cfg(input logic [2:0] sel, input logic [AW-1:0] a);
        @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_addr = a;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic go(input logic [AW-1:0] a, input int hold);
        @(negedge clk); bus_valid = 1; bus_addr = a;
        repeat (hold) @(negedge clk);
        bus_valid = 0;
        @(negedge clk);
    endtask

    task automatic expect_ev(input string tag, input int base, input int n,
                             input int code, input bit leave);
        checks++;
        if ((ev_cnt - base) != n || (n > 0 && (ev_code != code || ev_leave != leave))) begin
            errors++;
            $display("FAIL %s: actual events=%0d code=%0d leave=%0b expected events=%0d code=%0d leave=%0b",
                     tag, ev_cnt - base, ev_code, ev_leave, n, code, leave);
        end
    endtask

    task automatic finish_up();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R11: actual=hung expected=finished");
            finish_up();
        end
    end

    initial begin
        int b;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        checks++;
        if (evt_valid !== 0 || evt_code !== 0 || evt_leave_ready !== 0) begin
            errors++;
            $display("FAIL R1: actual v=%0b code=%0d leave=%0b expected 0 0 0", evt_valid, evt_code, evt_leave_ready);
        end
        // R2 unarmed entries never match (address 0 included)
        b = ev_cnt; go(12'h000, 1); go(A_RS, 1); expect_ev("R2 unarmed", b, 0, 0, 0);
        // R2 selector 5 ignored
        cfg(3'd5, A_X);
        b = ev_cnt; go(A_X, 1); expect_ev("R2 sel5 ignored", b, 0, 0, 0);
        cfg(3'd0, A_RS); cfg(3'd1, A_LK); cfg(3'd2, A_UL); cfg(3'd3, A_IN); cfg(3'd4, A_IO);
        cfg(3'd7, A_X);
        b = ev_cnt; go(A_X, 1); expect_ev("R2 sel7 ignored", b, 0, 0, 0);
        // R1 no pending prefix after reset -> unclassified; R8
        b = ev_cnt; go(A_RS, 1); expect_ev("R8 unclassified", b, 1, 7, 0);
        b = ev_cnt; go(A_IN, 1); go(A_RS, 1); expect_ev("R4 tick", b, 1, 1, 0);
        b = ev_cnt; go(A_IO, 1); go(A_RS, 1); expect_ev("R5 io", b, 1, 2, 0);
        b = ev_cnt; go(A_LK, 1); go(A_RS, 1); expect_ev("R6 block", b, 1, 3, 1);
        b = ev_cnt; go(A_UL, 1); go(A_RS, 1); expect_ev("R7 wake", b, 1, 4, 0);
        b = ev_cnt; go(A_LK, 1); go(A_IN, 1); go(A_RS, 1); expect_ev("R9 replace", b, 1, 1, 0);
        b = ev_cnt; go(A_IN, 1); go(A_LK, 2); go(A_RS, 1); expect_ev("R9 replace lock", b, 1, 3, 1);
        // R10 held address counts once
        b = ev_cnt; go(A_RS, 3); expect_ev("R10 held", b, 1, 7, 0);
        b = ev_cnt; go(A_UL, 3); go(A_RS, 2); expect_ev("R10 held prefix", b, 1, 4, 0);
        // R10 different address without gap
        b = ev_cnt;
        @(negedge clk); bus_valid = 1; bus_addr = A_IO;
        @(negedge clk); bus_addr = A_RS;
        @(negedge clk); bus_valid = 0;
        @(negedge clk);
        expect_ev("R10 back-to-back", b, 1, 2, 0);
        // R11 prefix cleared after event
        b = ev_cnt; go(A_IN, 1); go(A_RS, 1); go(A_RS, 1); expect_ev("R11 cleared", b, 2, 7, 0);
        // R3 valid low or non-matching address
        b = ev_cnt;
        @(negedge clk); bus_valid = 0; bus_addr = A_RS;
        @(negedge clk); go(A_RS + 12'h1, 1);
        expect_ev("R3 no match", b, 0, 0, 0);
        // R12 two entries share the reschedule address
        cfg(3'd3, A_RS);
        b = ev_cnt; go(A_LK, 1); go(A_RS, 1); expect_ev("R12 priority", b, 1, 3, 1);
        cfg(3'd3, A_IN);
        b = ev_cnt; go(A_IN, 1); go(A_RS, 1); expect_ev("R2 rewrite", b, 1, 1, 0);
        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule